// File: doc/BRIEF.md
# Vector Byte Permute and Select Unit

This block is a purely combinational 128-bit vector permute stage for a SIMD datapath. An opcode picks one of three results. The first is a byte shuffle. Each of the sixteen result bytes is taken from the 32-byte concatenation of vectors A and B, under a control byte drawn from vector C. A control byte can also ask for one of three constant fill values. The second is a mask expansion that turns a 16-bit immediate into sixteen byte-wide masks. The third is a bitwise merge of A and B under C.

Bytes are numbered big-endian throughout. Byte 0 is bits 127:120 of a vector and byte 15 is bits 7:0. In the A‖B concatenation, indices 0–15 name the bytes of A and indices 16–31 name the bytes of B. The block has no state machine, no registers and no states or transitions. The result depends only on the present inputs and settles in the same cycle.

Top module: `vperm_unit`

## Requirements
- R1: With opcode 2'b01 (shuffle), a control byte of 0x00–0x0F in byte lane i of C places byte (control value) of A into result byte i, where byte 0 is bits 127:120.
- R2: With opcode 2'b01, a control byte of 0x10–0x1F in lane i places byte (control value − 16) of B into result byte i.
- R3: With opcode 2'b01, a control byte of 0x20–0x7F uses only its low 5 bits as the index into A‖B.
- R4: With opcode 2'b01, a control byte matching 10xxxxxx gives result byte 0x00.
- R5: With opcode 2'b01, a control byte matching 110xxxxx gives result byte 0xFF.
- R6: With opcode 2'b01, a control byte matching 111xxxxx gives result byte 0x80.
- R7: Each result byte of a shuffle depends only on the control byte at the same position, so lanes with different control classes resolve independently in one operation.
- R8: With opcode 2'b10 (mask), result byte i is 0xFF when immediate bit (15 − i) is set and 0x00 when it is clear. For example, 0x9C1A gives FF,00,00,FF,FF,FF,00,00,00,00,00,FF,FF,00,FF,00.
- R9: With opcode 2'b11 (select), every result bit equals the B bit where the C bit is 1 and the A bit where the C bit is 0.
- R10: Opcode 2'b00 drives the result to all zeros, whatever the other inputs are.
- R11: The result follows a change on any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 none, 01 shuffle, 10 mask, 11 select |
| vec_a | input | 128 | Source vector A (first half of the shuffle pool, select value for 0 bits) |
| vec_b | input | 128 | Source vector B (second half of the shuffle pool, select value for 1 bits) |
| vec_c | input | 128 | Shuffle control bytes, or the select mask |
| imm16 | input | 16 | Immediate for mask expansion, MSB maps to byte 0 |
| result | output | 128 | Operation result |

## Verification
The block holds no state, so any fault in a lane decoder shows at once. It appears as a wrong byte in that lane's position of `result`, in the same cycle the inputs are applied. Mirrored byte numbering shows as bytes appearing at the opposite end of the vector. A mis-decoded fill class shows as 0x00, 0xFF or 0x80 landing where another constant or a source byte belongs. Every possible control byte is therefore swept through every lane, and every immediate value is applied to the mask path.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    typedef enum logic [1:0] {
        VP_NONE = 2'd0,
        VP_SHUF = 2'd1,
        VP_MASK = 2'd2,
        VP_SEL  = 2'd3
    } vp_op_e;

    typedef enum logic [1:0] {
        LC_INDEX = 2'd0,
        LC_ZERO  = 2'd1,
        LC_ONES  = 2'd2,
        LC_SIGN  = 2'd3
    } lane_cls_e;

    localparam logic [7:0] FILL_ZERO = 8'h00;
    localparam logic [7:0] FILL_ONES = 8'hFF;
    localparam logic [7:0] FILL_SIGN = 8'h80;

endpackage

// File: rtl/vperm_shuffle.sv
module vperm_shuffle #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] ctl_v,
    output logic [LANES*BYTE_W-1:0] shuf_v
);
    import vperm_pkg::*;

    localparam int VEC_W = LANES * BYTE_W;
    localparam int POOL  = 2 * LANES;
    localparam int IDX_W = $clog2(POOL);

    logic [2*VEC_W-1:0] pool_v;
    assign pool_v = {src_a, src_b};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] ctl;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] pick;
        lane_cls_e         cls;

        assign ctl = ctl_v[VEC_W-1-g*BYTE_W -: BYTE_W];
        assign idx = ctl[IDX_W-1:0];

        always_comb begin
            pick = '0;
            for (int k = 0; k < POOL; k++) begin
                if (idx == IDX_W'(k)) begin
                    pick = pool_v[2*VEC_W-1-k*BYTE_W -: BYTE_W];
                end
            end
        end

        always_comb begin
            if (!ctl[BYTE_W-1])      cls = LC_INDEX;
            else if (!ctl[BYTE_W-2]) cls = LC_ZERO;
            else if (!ctl[BYTE_W-3]) cls = LC_ONES;
            else                     cls = LC_SIGN;
        end

        always_comb begin
            unique case (cls)
                LC_INDEX: shuf_v[VEC_W-1-g*BYTE_W -: BYTE_W] = pick;
                LC_ZERO:  shuf_v[VEC_W-1-g*BYTE_W -: BYTE_W] = FILL_ZERO;
                LC_ONES:  shuf_v[VEC_W-1-g*BYTE_W -: BYTE_W] = FILL_ONES;
                LC_SIGN:  shuf_v[VEC_W-1-g*BYTE_W -: BYTE_W] = FILL_SIGN;
            endcase
        end
    end

endmodule

// File: rtl/vperm_maskgen.sv
module vperm_maskgen #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [LANES-1:0]        imm,
    output logic [LANES*BYTE_W-1:0] mask_v
);
    localparam int VEC_W = LANES * BYTE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask_v[VEC_W-1-g*BYTE_W -: BYTE_W] = {BYTE_W{imm[LANES-1-g]}};
    end

endmodule

// File: rtl/vperm_bitsel.sv
module vperm_bitsel #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] zero_src,
    input  logic [VEC_W-1:0] one_src,
    input  logic [VEC_W-1:0] chooser,
    output logic [VEC_W-1:0] merged
);
    for (genvar g = 0; g < VEC_W; g++) begin : g_bit
        assign merged[g] = chooser[g] ? one_src[g] : zero_src[g];
    end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [1:0]              op_sel,
    input  logic [LANES*BYTE_W-1:0] vec_a,
    input  logic [LANES*BYTE_W-1:0] vec_b,
    input  logic [LANES*BYTE_W-1:0] vec_c,
    input  logic [LANES-1:0]        imm16,
    output logic [LANES*BYTE_W-1:0] result
);
    import vperm_pkg::*;

    localparam int VEC_W = LANES * BYTE_W;

    logic [VEC_W-1:0] shuf_v;
    logic [VEC_W-1:0] mask_v;
    logic [VEC_W-1:0] sel_v;
    vp_op_e           op;

    assign op = vp_op_e'(op_sel);

    vperm_shuffle #(.LANES(LANES), .BYTE_W(BYTE_W)) u_shuf (
        .src_a  (vec_a),
        .src_b  (vec_b),
        .ctl_v  (vec_c),
        .shuf_v (shuf_v)
    );

    vperm_maskgen #(.LANES(LANES), .BYTE_W(BYTE_W)) u_mask (
        .imm    (imm16),
        .mask_v (mask_v)
    );

    vperm_bitsel #(.VEC_W(VEC_W)) u_sel (
        .zero_src (vec_a),
        .one_src  (vec_b),
        .chooser  (vec_c),
        .merged   (sel_v)
    );

    always_comb begin
        unique case (op)
            VP_NONE: result = '0;
            VP_SHUF: result = shuf_v;
            VP_MASK: result = mask_v;
            VP_SEL:  result = sel_v;
        endcase
    end

endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8
) (
    input logic [1:0]              op_sel,
    input logic [LANES*BYTE_W-1:0] vec_a,
    input logic [LANES*BYTE_W-1:0] vec_b,
    input logic [LANES*BYTE_W-1:0] vec_c,
    input logic [LANES-1:0]        imm16,
    input logic [LANES*BYTE_W-1:0] result
);
    localparam int VEC_W = LANES * BYTE_W;

    always_comb begin
        // R10: idle opcode yields zero
        a_r10_idle_zero: assert (op_sel != 2'b00 || result == '0);
        // R9: chosen bits follow B, others follow A
        a_r9_sel_ones:  assert (op_sel != 2'b11 || ((result ^ vec_b) & vec_c) == '0);
        a_r9_sel_zeros: assert (op_sel != 2'b11 || ((result ^ vec_a) & ~vec_c) == '0);
        for (int i = 0; i < LANES; i++) begin
            // R8: mask bytes are uniform and follow the immediate
            a_r8_mask_byte: assert (op_sel != 2'b10 ||
                result[VEC_W-1-i*BYTE_W -: BYTE_W] ==
                (imm16[LANES-1-i] ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}}));
            // R4: 10xxxxxx fills zero
            a_r4_fill_zero: assert (op_sel != 2'b01 ||
                vec_c[VEC_W-1-i*BYTE_W -: 2] != 2'b10 ||
                result[VEC_W-1-i*BYTE_W -: BYTE_W] == 8'h00);
            // R5: 110xxxxx fills ones
            a_r5_fill_ones: assert (op_sel != 2'b01 ||
                vec_c[VEC_W-1-i*BYTE_W -: 3] != 3'b110 ||
                result[VEC_W-1-i*BYTE_W -: BYTE_W] == 8'hFF);
            // R6: 111xxxxx fills 0x80
            a_r6_fill_sign: assert (op_sel != 2'b01 ||
                vec_c[VEC_W-1-i*BYTE_W -: 3] != 3'b111 ||
                result[VEC_W-1-i*BYTE_W -: BYTE_W] == 8'h80);
        end
    end

endmodule

bind vperm_unit vperm_unit_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) chk_i (
    .op_sel (op_sel),
    .vec_a  (vec_a),
    .vec_b  (vec_b),
    .vec_c  (vec_c),
    .imm16  (imm16),
    .result (result)
);

// File: tb/vperm_unit_tb_top.sv
`timescale 1ns/1ps
module vperm_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_sel = 2'b00;
    logic [127:0] vec_a = '0;
    logic [127:0] vec_b = '0;
    logic [127:0] vec_c = '0;
    logic [15:0]  imm16 = '0;
    logic [127:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    vperm_unit dut_i (
        .op_sel (op_sel),
        .vec_a  (vec_a),
        .vec_b  (vec_b),
        .vec_c  (vec_c),
        .imm16  (imm16),
        .result (result)
    );

    function automatic logic [7:0] byte_of(input logic [127:0] v, input int k);
        return v[127-8*k -: 8];
    endfunction

    // expected lane value from the requirements, with the requirement it exercises
    function automatic logic [7:0] lane_exp(input logic [7:0] c, input logic [127:0] a,
                                            input logic [127:0] b, output string tag);
        int n;
        if (c >= 8'hE0) begin tag = "R6"; return 8'h80; end
        if (c >= 8'hC0) begin tag = "R5"; return 8'hFF; end
        if (c >= 8'h80) begin tag = "R4"; return 8'h00; end
        n = int'(c) % 32;
        if (c >= 8'h20) tag = "R3";
        else if (c >= 8'h10) tag = "R2";
        else tag = "R1";
        if (n < 16) return byte_of(a, n);
        return byte_of(b, n - 16);
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a_pat;
        logic [127:0] b_pat;
        logic [127:0] exp;
        string        tag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset R10", result, '0);
        rst = 1'b0;

        for (int k = 0; k < 16; k++) begin
            a_pat[127-8*k -: 8] = 8'(8'h10 + 8'(k * 7));
            b_pat[127-8*k -: 8] = 8'(8'hA1 + 8'(k * 3));
        end

        // R1..R7: every control value in every lane, lanes mixed
        for (int v = 0; v < 256; v++) begin
            @(posedge clk);
            op_sel = 2'b01;
            vec_a  = a_pat;
            vec_b  = b_pat;
            for (int i = 0; i < 16; i++) vec_c[127-8*i -: 8] = 8'((v + i * 37) % 256);
            @(negedge clk);
            for (int i = 0; i < 16; i++) begin
                logic [7:0] e;
                e = lane_exp(vec_c[127-8*i -: 8], vec_a, vec_b, tag);
                total++;
                if (result[127-8*i -: 8] !== e) begin
                    bad++;
                    $display("FAIL %s R7 lane %0d ctl=%h got=%h exp=%h", tag, i,
                             vec_c[127-8*i -: 8], result[127-8*i -: 8], e);
                end
            end
        end

        // R1: identity and reversal controls
        @(posedge clk);
        for (int i = 0; i < 16; i++) vec_c[127-8*i -: 8] = 8'(i);
        @(negedge clk);
        check("R1 identity", result, a_pat);
        @(posedge clk);
        for (int i = 0; i < 16; i++) vec_c[127-8*i -: 8] = 8'(31 - i);
        @(negedge clk);
        for (int i = 0; i < 16; i++) exp[127-8*i -: 8] = byte_of(b_pat, 15 - i);
        check("R2 reverse B", result, exp);

        // R8: the worked example, then every immediate
        @(posedge clk);
        op_sel = 2'b10;
        imm16  = 16'h9C1A;
        @(negedge clk);
        check("R8 example", result, 128'hFF0000FFFFFF0000000000FFFF00FF00);
        for (int m = 0; m < 65536; m++) begin
            @(posedge clk);
            imm16 = 16'(m);
            @(negedge clk);
            for (int i = 0; i < 16; i++) exp[127-8*i -: 8] = ((m >> (15 - i)) & 1) != 0 ? 8'hFF : 8'h00;
            check("R8 sweep", result, exp);
        end

        // R9: arithmetic patterns
        for (int s = 0; s < 64; s++) begin
            @(posedge clk);
            op_sel = 2'b11;
            for (int w = 0; w < 4; w++) begin
                vec_a[32*w +: 32] = 32'(s * 32'h9E3779B9 + w * 32'h01234567);
                vec_b[32*w +: 32] = 32'(s * 32'h7F4A7C15 + w * 32'h89ABCDEF);
                vec_c[32*w +: 32] = 32'(s * 32'h5851F42D ^ w * 32'h2545F491);
            end
            @(negedge clk);
            for (int j = 0; j < 128; j++) exp[j] = vec_c[j] ? vec_b[j] : vec_a[j];
            check("R9 select", result, exp);
        end

        // R10: idle opcode with busy inputs
        @(posedge clk);
        op_sel = 2'b00;
        vec_a = '1; vec_b = '1; vec_c = '1; imm16 = '1;
        @(negedge clk);
        check("R10 idle", result, '0);

        // R11: change inputs between edges, observe without any edge
        @(negedge clk);
        op_sel = 2'b10;
        imm16  = 16'h8001;
        #0.5;
        check("R11 mask immediate", result, {8'hFF, 112'h0, 8'hFF});
        imm16 = 16'h0100;
        #0.5;
        check("R11 follow", result, {56'h0, 8'hFF, 64'h0});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule